// File: doc/BRIEF.md
# Dual-Source Value Prediction Arbiter

This block merges two value predictors into one prediction per request. One source is an external predictor that works from control-flow history; it supplies a value and a confident flag on input ports. The second source is a small stride table inside the block. Each entry holds the committed last value, a speculative last value, a stride and a 3-bit confidence counter. The stride source predicts the speculative last value plus the stride.

Arbitration works as follows. A lone confident source wins. Two confident sources that agree give a prediction. Two confident sources that disagree give no prediction. A confident prediction is written back as the entry's speculative last value, so the next prediction of the same instruction builds on it, even when that prediction came from the history source.

At retirement the stride entry is trained with the committed value. The same index and value are also passed out to train the history source.

Top module: `vpa_top`

## Requirements
- R1: The table index is the low 4 bits of ({pc, 2'b00} XOR uop). Requests whose pc and uop give the same index share one entry, and requests with different indices use different entries.
- R2: After reset every entry holds zero in all fields. A request right after reset therefore gives pred_valid low.
- R3: If only hist_conf is high, pred_valid is high and pred_value equals hist_value.
- R4: The stride source is confident when its counter equals 7. If only the stride source is confident, pred_value equals the entry's speculative last value plus its stride.
- R5: If both sources are confident and their values are equal, pred_valid is high with that value.
- R6: If both sources are confident and their values differ, pred_valid is low.
- R7: If neither source is confident, pred_valid is low. Whenever pred_valid is low, pred_value is zero.
- R8: On a request with hist_conf high, the entry's speculative last value becomes hist_value. On a request with neither source confident, the speculative last value is left as it was.
- R9: On a request where only the stride source is confident, the speculative last value becomes the stride prediction. Back-to-back requests therefore advance by one stride each.
- R10: At retirement the new stride is the committed value minus the stored last value. The counter increments, saturating at 7, if the new stride equals the old one; otherwise the counter clears. Both the last value and the speculative last value become the committed value.
- R11: In the same cycle as ret_valid, train_valid, train_idx and train_value present ret_valid, the R1 index of ret_pc/ret_uop, and ret_value.
- R12: If a request and a retirement hit the same entry in one cycle, the prediction uses the old state and the retirement's value wins in the speculative last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Prediction request |
| req_pc | input | 16 | Instruction address of request |
| req_uop | input | 2 | Micro-op number of request |
| hist_conf | input | 1 | History source is confident |
| hist_value | input | 32 | History source predicted value |
| pred_valid | output | 1 | Final prediction is usable |
| pred_value | output | 32 | Final predicted value (zero when not valid) |
| ret_valid | input | 1 | Retirement of a predicted instruction |
| ret_pc | input | 16 | Instruction address at retirement |
| ret_uop | input | 2 | Micro-op number at retirement |
| ret_value | input | 32 | Committed result |
| train_valid | output | 1 | Training strobe to history source |
| train_idx | output | 4 | Training index to history source |
| train_value | output | 32 | Training value to history source |

## Verification
The assertions check the arbitration rules on every cycle: a disagreement never yields a prediction, a lone history prediction passes through, and the output is zero when it is not valid. They also check the entry bookkeeping: the speculative value is written, or held, as the request asks; the counter clears on a stride change and holds at saturation. Three things are only shown by the bench's scenarios, which compare against a model of the table: building confidence over a run of retirements, index aliasing, and a request and a retirement colliding on the same entry.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
  parameter int VAL_W  = 32;
  parameter int IDX_W  = 4;
  parameter int PC_W   = 16;
  parameter int UOP_W  = 2;
  parameter int CONF_W = 3;

  localparam int DEPTH  = 1 << IDX_W;
  localparam int HASH_W = PC_W + 2;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  typedef logic [VAL_W-1:0] val_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    val_t              last;
    val_t              spec;
    val_t              stride;
    logic [CONF_W-1:0] conf;
  } sentry_t;

  // table index: address shifted by two, mixed with micro-op number
  function automatic idx_t idx_of(logic [PC_W-1:0] pc, logic [UOP_W-1:0] uop);
    logic [HASH_W-1:0] h;
    h = {pc, 2'b00} ^ {{(HASH_W-UOP_W){1'b0}}, uop};
    return h[IDX_W-1:0];
  endfunction

  function automatic val_t stride_pred(sentry_t e);
    return e.spec + e.stride;
  endfunction

  function automatic sentry_t retire_upd(sentry_t e, val_t v);
    sentry_t r;
    val_t    ns;
    ns = v - e.last;
    r  = e;
    if (ns == e.stride) r.conf = (e.conf == CONF_MAX) ? e.conf : e.conf + 1'b1;
    else                r.conf = '0;
    r.stride = ns;
    r.last   = v;
    r.spec   = v;
    return r;
  endfunction
endpackage

// File: rtl/vpa_select.sv
module vpa_select
  import vpa_pkg::*;
(
  input  logic req,
  input  logic hist_conf,
  input  val_t hist_val,
  input  logic str_conf,
  input  val_t str_val,
  output logic valid,
  output val_t value,
  output logic spec_we,
  output val_t spec_val
);
  logic both_conf;
  logic agree;

  assign both_conf = hist_conf && str_conf;
  assign agree     = (hist_val == str_val);

  always_comb begin
    valid = 1'b0;
    value = '0;
    if (req) begin
      if (both_conf) begin
        valid = agree;
        value = agree ? hist_val : '0;
      end else if (hist_conf) begin
        valid = 1'b1;
        value = hist_val;
      end else if (str_conf) begin
        valid = 1'b1;
        value = str_val;
      end
    end
  end

  // speculative last value: history source first, else own stride prediction
  assign spec_we  = req && (hist_conf || str_conf);
  assign spec_val = hist_conf ? hist_val : str_val;
endmodule

// File: rtl/vpa_stride_table.sv
module vpa_stride_table
  import vpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  idx_t rd_idx,
  output val_t rd_pred,
  output logic rd_conf,
  input  logic spec_we,
  input  val_t spec_val,
  input  logic ret_we,
  input  idx_t ret_idx,
  input  val_t ret_val
);
  sentry_t tbl [DEPTH];
  sentry_t rd_entry;
  sentry_t ret_entry;
  logic    ret_stride_change;
  logic    ret_hits_rd;

  assign rd_entry          = tbl[rd_idx];
  assign ret_entry         = tbl[ret_idx];
  assign rd_pred           = stride_pred(rd_entry);
  assign rd_conf           = (rd_entry.conf == CONF_MAX);
  assign ret_stride_change = (ret_val - ret_entry.last) != ret_entry.stride;
  assign ret_hits_rd       = ret_we && (ret_idx == rd_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else begin
      if (spec_we) tbl[rd_idx].spec <= spec_val;
      if (ret_we)  tbl[ret_idx]     <= retire_upd(ret_entry, ret_val);
    end
  end

  // R8 / R9: written speculative value lands in the entry
  a_r8_spec_written: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_we && !ret_hits_rd) |=> tbl[$past(rd_idx)].spec == $past(spec_val));

  // R8: no confident source leaves the speculative value alone
  a_r8_spec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_we && !ret_hits_rd) |=> tbl[$past(rd_idx)].spec == $past(rd_entry.spec));

  a_r10_conf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_we && ret_stride_change) |=> tbl[$past(ret_idx)].conf == '0);

  a_r10_conf_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_we && !ret_stride_change && ret_entry.conf == CONF_MAX)
      |=> tbl[$past(ret_idx)].conf == CONF_MAX);

  // R12: retirement takes precedence over a same-entry speculative write
  a_r12_retire_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ret_we |=> tbl[$past(ret_idx)].spec == $past(ret_val));
endmodule

// File: rtl/vpa_top.sv
module vpa_top
  import vpa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PC_W-1:0]  req_pc,
  input  logic [UOP_W-1:0] req_uop,
  input  logic             hist_conf,
  input  logic [VAL_W-1:0] hist_value,
  output logic             pred_valid,
  output logic [VAL_W-1:0] pred_value,
  input  logic             ret_valid,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic [UOP_W-1:0] ret_uop,
  input  logic [VAL_W-1:0] ret_value,
  output logic             train_valid,
  output logic [IDX_W-1:0] train_idx,
  output logic [VAL_W-1:0] train_value
);
  idx_t req_idx;
  idx_t ret_idx;
  val_t str_pred;
  logic str_conf;
  logic spec_we;
  val_t spec_val;

  assign req_idx = idx_of(req_pc, req_uop);
  assign ret_idx = idx_of(ret_pc, ret_uop);

  vpa_stride_table u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_pred  (str_pred),
    .rd_conf  (str_conf),
    .spec_we  (spec_we),
    .spec_val (spec_val),
    .ret_we   (ret_valid),
    .ret_idx  (ret_idx),
    .ret_val  (ret_value)
  );

  vpa_select u_sel (
    .req       (req_valid),
    .hist_conf (hist_conf),
    .hist_val  (hist_value),
    .str_conf  (str_conf),
    .str_val   (str_pred),
    .valid     (pred_valid),
    .value     (pred_value),
    .spec_we   (spec_we),
    .spec_val  (spec_val)
  );

  // training of the history source
  assign train_valid = ret_valid;
  assign train_idx   = ret_idx;
  assign train_value = ret_value;

  a_r6_disagree_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_conf && str_conf && hist_value != str_pred) |-> !pred_valid);

  a_r3_hist_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hist_conf && !str_conf) |-> (pred_valid && pred_value == hist_value));

  a_r7_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> pred_value == '0);

  a_r7_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> req_valid);
endmodule

// File: tb/vpa_top_tb.sv
module vpa_top_tb;
  localparam int CLK_P = 10;
  localparam int N     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, hist_conf = 1'b0, ret_valid = 1'b0;
  logic [15:0] req_pc = '0, ret_pc = '0;
  logic [1:0]  req_uop = '0, ret_uop = '0;
  logic [31:0] hist_value = '0, ret_value = '0;
  logic        pred_valid, train_valid;
  logic [31:0] pred_value, train_value;
  logic [3:0]  train_idx;

  always #(CLK_P/2) clk = ~clk;

  vpa_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
    .req_uop(req_uop), .hist_conf(hist_conf), .hist_value(hist_value),
    .pred_valid(pred_valid), .pred_value(pred_value), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .ret_uop(ret_uop), .ret_value(ret_value),
    .train_valid(train_valid), .train_idx(train_idx), .train_value(train_value)
  );

  // bench model of the stride table
  logic [31:0] m_last [N];
  logic [31:0] m_spec [N];
  logic [31:0] m_strd [N];
  int          m_conf [N];

  typedef struct packed {
    logic        pv;
    logic [31:0] pval;
    logic        tv;
    logic [3:0]  tidx;
    logic [31:0] tval;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int    n_chk = 0, n_bad = 0;
  bit    done = 0;

  function automatic logic [3:0] midx(logic [15:0] pc, logic [1:0] uop);
    logic [17:0] t;
    t = ({pc, 2'b00}) ^ {16'd0, uop};
    return t[3:0];
  endfunction

  task automatic drive(bit rq, logic [15:0] pc, logic [1:0] uop, bit hc, logic [31:0] hv,
                       bit rt, logic [15:0] rpc, logic [1:0] ruop, logic [31:0] rv,
                       string tag);
    exp_t        e;
    logic [3:0]  qi, ri;
    logic [31:0] sp;
    logic [31:0] d;
    bit          sc;
    @(negedge clk);
    req_valid = rq; req_pc = pc; req_uop = uop; hist_conf = hc; hist_value = hv;
    ret_valid = rt; ret_pc = rpc; ret_uop = ruop; ret_value = rv;
    qi = midx(pc, uop);
    ri = midx(rpc, ruop);
    sp = m_spec[qi] + m_strd[qi];
    sc = (m_conf[qi] == 7);
    e = '0;
    if (rq) begin
      if (hc && sc)  begin e.pv = (hv == sp); e.pval = (hv == sp) ? hv : 32'd0; end
      else if (hc)   begin e.pv = 1'b1; e.pval = hv; end
      else if (sc)   begin e.pv = 1'b1; e.pval = sp; end
    end
    e.tv = rt; e.tidx = rt ? ri : midx(rpc, ruop); e.tval = rv;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    // model update: speculative write, then retirement overrides
    if (rq && hc)      m_spec[qi] = hv;
    else if (rq && sc) m_spec[qi] = sp;
    if (rt) begin
      d = rv - m_last[ri];
      if (d == m_strd[ri]) m_conf[ri] = (m_conf[ri] == 7) ? 7 : m_conf[ri] + 1;
      else                 m_conf[ri] = 0;
      m_strd[ri] = d; m_last[ri] = rv; m_spec[ri] = rv;
    end
  endtask

  // monitor: compares just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/2 - 1);
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (pred_valid !== e.pv || pred_value !== e.pval) begin
          n_bad++;
          $display("FAIL %s pred act=%0b/%0d exp=%0b/%0d", t, pred_valid, pred_value, e.pv, e.pval);
        end
        if (train_valid !== e.tv || train_value !== e.tval || (e.tv && train_idx !== e.tidx)) begin
          n_bad++;
          $display("FAIL %s R11 train act=%0b/%0d/%0d exp=%0b/%0d/%0d", t,
                   train_valid, train_idx, train_value, e.tv, e.tidx, e.tval);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_last[i] = 0; m_spec[i] = 0; m_strd[i] = 0; m_conf[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: fresh table is not confident
    drive(1, 16'd1, 2'd0, 0, 0, 0, 0, 0, 0, "R2 reset");
    // R10 / R11: build confidence on entry of pc=1 with stride 10
    for (int k = 0; k < 10; k++)
      drive(0, 0, 0, 0, 0, 1, 16'd1, 2'd0, 32'(100 + 10*k), "R10 train");
    drive(1, 16'd1, 2'd0, 0, 0, 0, 0, 0, 0, "R4 stride alone");
    drive(1, 16'd1, 2'd0, 0, 0, 0, 0, 0, 0, "R9 back-to-back");
    drive(1, 16'd1, 2'd0, 1, 32'd220, 0, 0, 0, 0, "R5 agree");
    drive(1, 16'd1, 2'd0, 1, 32'd999, 0, 0, 0, 0, "R6 disagree");
    drive(1, 16'd1, 2'd0, 0, 0, 0, 0, 0, 0, "R8 hist cross-feed");
    drive(1, 16'd5, 2'd0, 0, 0, 0, 0, 0, 0, "R1 alias");
    drive(1, 16'd1, 2'd1, 0, 0, 0, 0, 0, 0, "R1 distinct uop");
    drive(1, 16'd2, 2'd0, 1, 32'd55, 0, 0, 0, 0, "R3 hist alone");
    drive(1, 16'd2, 2'd0, 0, 0, 0, 0, 0, 0, "R7 neither");
    drive(1, 16'd1, 2'd0, 0, 0, 1, 16'd1, 2'd0, 32'd200, "R12 collide");
    drive(1, 16'd1, 2'd0, 0, 0, 0, 0, 0, 0, "R12 retire wins");
    drive(0, 0, 0, 0, 0, 1, 16'd1, 2'd0, 32'd500, "R10 stride break");
    drive(1, 16'd1, 2'd0, 0, 0, 0, 0, 0, 0, "R10 cleared");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 idle");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule